// File: doc/BRIEF.md
# Refresh Memory Address Generator

This block produces the display memory address for a character-based raster controller. It keeps a running character address counter and a register holding the start address of the next character row. An external timing section supplies the column, raster-line and row counts, a display-enable flag and a row-end strobe. Software programs a start address through a byte-wide write port, one byte for the upper bits and one for the lower bits.

The character address is combined with the low raster-line bits to form the memory address. Within a row, every raster line walks the same run of character addresses. The next row continues where the previous row's displayed run ended. A newly written start address only takes hold at the frame origin, which is the one cycle in which column, raster and row counts are all zero. Software can therefore update both bytes at any time within a frame without producing a torn address. The block assumes one clock per character.

Top module: `refresh_addr_gen`

## Requirements
- R1: After reset, the start register, the character counter and the next-row register all hold zero. The first non-origin column-zero cycle therefore presents character address 0.
- R2: `mem_addr` carries the presented character address in bits [16:3] and raster count bits [2:0] in bits [2:0]. It is combinational from the current inputs and state.
- R3: A write with `wr_hi`=0 puts `wr_data[7:0]` into start bits [7:0]. A write with `wr_hi`=1 puts `wr_data[5:0]` into start bits [13:8]; `wr_data[7:6]` is ignored.
- R4: In a frame-origin cycle (column, raster and row all zero), the presented character address equals the start register. Both the counter and the next-row register restart from that value.
- R5: A start-address write changes neither the presented address nor the next-row register until the next frame origin. A write issued in an origin cycle is first used at the following origin.
- R6: On each cycle with `disp_en` high, the address presented on the next cycle is one higher, unless that next cycle is at column zero. With `disp_en` low, the address holds.
- R7: In a column-zero cycle that is not a frame origin, the presented address is the next-row register. Every raster line of a row therefore repeats the row's addresses.
- R8: When `row_end` is high, the next-row register captures the address presented in that cycle. The following raster line then starts from there.
- R9: All address arithmetic wraps modulo 2^14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_cnt | input | 8 | Column count within the raster line |
| ras_cnt | input | 5 | Raster-line count within the character row |
| row_cnt | input | 7 | Character-row count within the frame |
| disp_en | input | 1 | High while the current column is displayed |
| row_end | input | 1 | Strobe at the first undisplayed column of a row's last raster line |
| wr_en | input | 1 | Start-address byte write |
| wr_hi | input | 1 | 1 selects the upper start bits, 0 the lower byte |
| wr_data | input | 8 | Write data |
| mem_addr | output | 17 | Character address above raster bits [2:0] |

## Verification
The assertions rely on the timing inputs advancing one character per clock and never skipping column zero at a raster start. They also expect `row_end` to arrive only at the point where the next row's start should be taken. The assertions about stepping and holding tolerate any `disp_en` pattern, because they exempt column-zero cycles. The bench generates whole frames from nested column, raster and row loops. It raises `disp_en` for the leading columns and pulses `row_end` at the first undisplayed column of each row's final raster line, so every input sequence follows a legal scan order.

// File: rtl/refresh_addr_gen.sv
module refresh_addr_gen #(
  parameter int ADDR_W  = 14,
  parameter int COL_W   = 8,
  parameter int RAS_W   = 5,
  parameter int ROW_W   = 7,
  parameter int DATA_W  = 8,
  parameter int RAS_OUT = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [COL_W-1:0]          col_cnt,
  input  logic [RAS_W-1:0]          ras_cnt,
  input  logic [ROW_W-1:0]          row_cnt,
  input  logic                      disp_en,
  input  logic                      row_end,
  input  logic                      wr_en,
  input  logic                      wr_hi,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [ADDR_W+RAS_OUT-1:0] mem_addr
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] start_q, vma_q, nxt_q, eff;
  logic origin, row_start;

  assign origin    = (col_cnt == '0) && (ras_cnt == '0) && (row_cnt == '0);
  assign row_start = (col_cnt == '0);
  assign eff       = origin ? start_q : (row_start ? nxt_q : vma_q);
  assign mem_addr  = {eff, ras_cnt[RAS_OUT-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
    end else if (wr_en) begin
      if (wr_hi) start_q[ADDR_W-1:DATA_W] <= wr_data[HI_W-1:0];
      else       start_q[DATA_W-1:0]      <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vma_q <= '0;
      nxt_q <= '0;
    end else begin
      vma_q <= disp_en ? eff + ADDR_W'(1) : eff;
      if (origin || row_end) nxt_q <= eff;
    end
  end

  // R6
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |=> (col_cnt == '0 || eff == $past(eff) + ADDR_W'(1)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |=> (col_cnt == '0 || eff == $past(eff)));

  // R8
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_end && !origin) |=> (nxt_q == $past(eff)));

  // R5
  nxt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(origin || row_end) |=> $stable(nxt_q));

  // R3
  lo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi) |=> (start_q[DATA_W-1:0] == $past(wr_data)));

  // R4
  origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    origin |=> (nxt_q == $past(start_q)));
endmodule

// File: tb/refresh_addr_gen_test.sv
module refresh_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  col_cnt = '0;
  logic [4:0]  ras_cnt = 5'd1;
  logic [6:0]  row_cnt = '0;
  logic        disp_en = 1'b0;
  logic        row_end = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_hi = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [16:0] mem_addr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  refresh_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .col_cnt(col_cnt), .ras_cnt(ras_cnt),
    .row_cnt(row_cnt), .disp_en(disp_en), .row_end(row_end),
    .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data), .mem_addr(mem_addr)
  );

  task automatic drive(input int c, input int s, input int r, input bit de,
                       input bit re, input bit we, input bit hi, input int d);
    col_cnt = 8'(c); ras_cnt = 5'(s); row_cnt = 7'(r);
    disp_en = de; row_end = re; wr_en = we; wr_hi = hi; wr_data = 8'(d);
    #2;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [13:0] ea, input logic [2:0] eb);
    checks++;
    if (mem_addr !== {ea, eb}) begin
      fails++;
      $display("FAIL %s: mem_addr actual %h expected %h", req, mem_addr, {ea, eb});
    end
  endtask

  task automatic wr_start(input logic [13:0] v);
    drive(0, 1, 0, 0, 0, 1, 1, {2'b11, v[13:8]}); tick();
    drive(0, 1, 0, 0, 0, 1, 0, v[7:0]); tick();
    drive(0, 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic run_frame(input string req, input logic [13:0] st, input int n);
    for (int r = 0; r < 3; r++)
      for (int s = 0; s < 2; s++)
        for (int c = 0; c < 6; c++) begin
          drive(c, s, r, c < n, (c == n) && (s == 1), 0, 0, 0);
          chk(req, st + 14'(r * n) + 14'((c < n) ? c : n), 3'(s));
          tick();
        end
  endtask

  task automatic t_reset();
    drive(0, 1, 0, 0, 0, 0, 0, 0);
    chk("R1", 14'h0, 3'd1);
    drive(0, 5, 2, 0, 0, 0, 0, 0);
    chk("R2", 14'h0, 3'd5);
  endtask

  task automatic t_deferred();
    wr_start(14'h0520);
    chk("R5", 14'h0, 3'd1);
    drive(0, 3, 4, 0, 0, 0, 0, 0);
    chk("R5", 14'h0, 3'd3);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R4", 14'h0520, 3'd0);
    tick();
  endtask

  task automatic t_frame();
    run_frame("R6 R7 R8", 14'h0520, 4);
  endtask

  task automatic t_wrap();
    wr_start(14'h3FFE);
    run_frame("R9 R3", 14'h3FFE, 4);
  endtask

  task automatic t_origin_write();
    wr_start(14'h0100);
    drive(0, 0, 0, 1, 0, 1, 0, 8'h55);
    chk("R5", 14'h0100, 3'd0);
    tick();
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R5", 14'h0101, 3'd0);
    tick();
    drive(0, 1, 0, 0, 0, 0, 0, 0);
    chk("R7", 14'h0100, 3'd1);
    tick();
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R4", 14'h0155, 3'd0);
    tick();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_deferred();
    t_frame();
    t_wrap();
    t_origin_write();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule